// File: doc/BRIEF.md
# TDM daisy-chain DAC serial port

This block is the receive side of the DAC serial port of one audio converter that shares a single time-division-multiplexed stream with a second, identical converter. The processor drives the stream into the nearer device. That device keeps the last eight 32-bit slots of each frame as its own eight channels. It also forwards its whole input, delayed by exactly eight slots, on its serial output to the farther device. The farther device sees its data arrive in the same slot positions and applies the same rule, so both devices run the same logic. The input of the device at the far end of the chain is tied low.

The block runs on a fast system clock and oversamples the bit clock, frame clock and data lines. Configuration inputs choose the active bit-clock edge, the frame-clock edge that marks a frame, and whether the first data bit comes one bit after that edge (I2S, the all-zero setting) or on the same bit. In dual-line mode the frame is split across two data lines of eight slots each. On each line, slots 4 to 7 belong to this device and the delay is four slots, which halves the bit-clock rate. A three-state machine locks onto the stream: HUNT waits for the first frame start (transition LOCK to FILL). FILL collects the first frame and, at the next frame start, publishes it (transition FIRST_DONE to RUN). RUN publishes at every later frame start (transition REPUBLISH, staying in RUN).

Top module: `tdm_chain_dac_port`

## Requirements
- R1: During and after reset, sdout0, sdout1 and frame_vld are low and every ch_word is zero. ch_word stays zero until a complete frame, bounded by two detected frame starts, has been received.
- R2: The active bit-clock edge is rising when cfg_bclk_fall=0 and falling when cfg_bclk_fall=1. Data and frame clock are sampled only at active edges.
- R3: A frame start is detected when the frame-clock sample changes to the active level between two active bit edges. The active level is low (falling transition) when cfg_frm_rise=0 and high (rising transition) when cfg_frm_rise=1. With cfg_left=0 (I2S) the MSB of slot 0 is the bit after that transition; with cfg_left=1 it is the same bit.
- R4: With cfg_dual=0 a frame is 512 bits, made of 16 slots of 32 bits. Slots 8 to 15 land in ch_word[0] to ch_word[7] in order (L1, R1, L2, R2, L3, R3, L4, R4).
- R5: Each slot is MSB first. ch_word[c] receives slot bits 31:8, and slot bits 7:0 have no effect on any output.
- R6: With cfg_dual=1 each line carries a 256-bit frame of 8 slots. Slots 4 to 7 of sdin0 go to ch_word[0..3], and slots 4 to 7 of sdin1 go to ch_word[4..7].
- R7: Sampled at active edges, sdout0 equals sdin0 from 256 active edges earlier (cfg_dual=0) or 128 (cfg_dual=1). With cfg_dual=1, sdout1 equals sdin1 from 128 edges earlier. Before enough edges have passed since reset, the outputs are 0. The outputs change only in the cycle after an active edge.
- R8: With cfg_dual=0, sdin1 has no effect and sdout1 stays low.
- R9: frame_vld is a one-cycle pulse at each frame start that ends a complete frame. All eight ch_word entries change together in that cycle and hold at all other times.
- R10: frame_vld is never raised before the state machine has left HUNT and FILL, and the machine never returns to HUNT until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_dual | input | 1 | 1 selects dual-line mode |
| cfg_bclk_fall | input | 1 | 1 makes the falling bit-clock edge the active one |
| cfg_frm_rise | input | 1 | 1 makes a rising frame-clock transition mark a frame |
| cfg_left | input | 1 | 1 puts slot 0 MSB on the frame-edge bit; 0 is I2S one-bit delay |
| bclk_in | input | 1 | Serial bit clock |
| frm_in | input | 1 | Serial frame clock |
| sdin0 | input | 1 | Serial data from upstream, line 0 |
| sdin1 | input | 1 | Serial data from upstream, line 1 (dual-line mode) |
| sdout0 | output | 1 | Delayed serial data to the next device, line 0 |
| sdout1 | output | 1 | Delayed serial data to the next device, line 1 |
| ch_word | output | NCH*SAMP_W | Captured channel words, ch_word[c] for channel c |
| frame_vld | output | 1 | One-cycle pulse when all channel words update |

## Verification
The assertions assume that the configuration inputs are held steady while out of reset. They also assume that the bit clock holds each level for at least two system clocks, so that one active edge yields one isolated sample strobe and a publish pulse cannot repeat in the next cycle. The bench meets these conditions by changing the configuration only while reset is asserted, and by holding each bit-clock phase for four system clocks with data and frame clock moved at the inactive edge. It sweeps all sixteen settings of the four configuration inputs, with distinct slot contents in every run whose low eight bits are non-zero.

// File: rtl/tdm_chain_pkg.sv
package tdm_chain_pkg;

    // Lock state of the frame tracker
    typedef enum logic [1:0] {
        ST_HUNT = 2'd0,
        ST_FILL = 2'd1,
        ST_RUN  = 2'd2
    } sync_st_t;

    localparam int NUM_LINES = 2;

endpackage

// File: rtl/tdm_pin_sampler.sv
// Oversamples the serial pins and produces one strobe per active bit edge
module tdm_pin_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_bclk_fall,
    input  logic cfg_frm_rise,
    input  logic bclk_in,
    input  logic frm_in,
    input  logic sdin0,
    input  logic sdin1,
    output logic bit_stb,
    output logic [1:0] bit_d,
    output logic frm_edge
);

    logic s_bclk, p_bclk, s_frm, s_d0, s_d1;
    logic frm_last, primed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_bclk <= cfg_bclk_fall;
            p_bclk <= cfg_bclk_fall;
            s_frm  <= 1'b0;
            s_d0   <= 1'b0;
            s_d1   <= 1'b0;
        end else begin
            s_bclk <= bclk_in;
            p_bclk <= s_bclk;
            s_frm  <= frm_in;
            s_d0   <= sdin0;
            s_d1   <= sdin1;
        end
    end

    // active edge: rising unless the falling edge is selected
    assign bit_stb = cfg_bclk_fall ? (p_bclk & ~s_bclk) : (~p_bclk & s_bclk);
    assign bit_d   = {s_d1, s_d0};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frm_last <= 1'b0;
            primed   <= 1'b0;
        end else if (bit_stb) begin
            frm_last <= s_frm;
            primed   <= 1'b1;
        end
    end

    // transition into the active frame level, seen between two bit samples
    assign frm_edge = bit_stb && primed &&
                      (s_frm == cfg_frm_rise) && (frm_last != cfg_frm_rise);

endmodule

// File: rtl/tdm_delay_line.sv
// Per-line bit delay that forwards the stream to the next device
module tdm_delay_line #(
    parameter int DLY_BITS = 256
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       shift_en,
    input  logic       cfg_dual,
    input  logic [1:0] din,
    output logic       dout0,
    output logic       dout1
);

    localparam int HALF_BITS = DLY_BITS / 2;

    logic [1:0] tap;

    for (genvar ln = 0; ln < tdm_chain_pkg::NUM_LINES; ln++) begin : g_line
        localparam int LW = (ln == 0) ? DLY_BITS : HALF_BITS;
        logic [LW-1:0] sr;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                sr <= '0;
            else if (shift_en)
                sr <= {sr[LW-2:0], din[ln]};
        end

        assign tap[ln] = cfg_dual ? sr[HALF_BITS-1] : sr[LW-1];
    end

    assign dout0 = tap[0];
    assign dout1 = cfg_dual & tap[1];

endmodule

// File: rtl/tdm_slot_capture.sv
// Bit position tracking, slot assembly and staging of this device's channels
module tdm_slot_capture #(
    parameter int SLOT_W = 32,
    parameter int SAMP_W = 24,
    parameter int NCH    = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bit_stb,
    input  logic [1:0]                 bit_d,
    input  logic                       start_now,
    input  logic                       cap_en,
    input  logic                       cfg_dual,
    output logic [NCH-1:0][SAMP_W-1:0] stage
);

    localparam int SLOT_SH = $clog2(SLOT_W);
    localparam int GRP_W   = $clog2(NCH);
    localparam int CNT_W   = SLOT_SH + GRP_W + 1;
    localparam int SUB_W   = GRP_W - 1;

    logic [CNT_W-1:0]  cnt, pos;
    logic [1:0][SLOT_W-1:0] slot_sr;
    logic [SLOT_W-1:0] w0, w1;
    logic              slot_end, own;
    logic [GRP_W-1:0]  idx_a, idx_b;

    always_comb begin
        pos = start_now ? '0 : cnt + CNT_W'(1);
        if (cfg_dual)
            pos[CNT_W-1] = 1'b0;
    end

    assign w0       = {slot_sr[0][SLOT_W-2:0], bit_d[0]};
    assign w1       = {slot_sr[1][SLOT_W-2:0], bit_d[1]};
    assign slot_end = &pos[SLOT_SH-1:0];

    // own group is the second half of the frame (per line in dual mode)
    always_comb begin
        if (cfg_dual) begin
            own   = pos[CNT_W-2];
            idx_a = {1'b0, pos[SLOT_SH+SUB_W-1:SLOT_SH]};
            idx_b = {1'b1, pos[SLOT_SH+SUB_W-1:SLOT_SH]};
        end else begin
            own   = pos[CNT_W-1];
            idx_a = pos[SLOT_SH+GRP_W-1:SLOT_SH];
            idx_b = pos[SLOT_SH+GRP_W-1:SLOT_SH];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            slot_sr <= '0;
            stage   <= '0;
        end else if (bit_stb) begin
            cnt        <= pos;
            slot_sr[0] <= w0;
            slot_sr[1] <= w1;
            if (cap_en && slot_end && own) begin
                stage[idx_a] <= w0[SLOT_W-1 -: SAMP_W];
                if (cfg_dual)
                    stage[idx_b] <= w1[SLOT_W-1 -: SAMP_W];
            end
        end
    end

endmodule

// File: rtl/tdm_chain_dac_port.sv
// DAC-side serial input port of one device in a two-device TDM chain
module tdm_chain_dac_port #(
    parameter int SLOT_W = 32,
    parameter int SAMP_W = 24,
    parameter int NCH    = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_dual,
    input  logic                       cfg_bclk_fall,
    input  logic                       cfg_frm_rise,
    input  logic                       cfg_left,
    input  logic                       bclk_in,
    input  logic                       frm_in,
    input  logic                       sdin0,
    input  logic                       sdin1,
    output logic                       sdout0,
    output logic                       sdout1,
    output logic [NCH-1:0][SAMP_W-1:0] ch_word,
    output logic                       frame_vld
);

    import tdm_chain_pkg::*;

    localparam int DLY_BITS = NCH * SLOT_W;

    logic       bit_stb, frm_edge, edge_q, start_now, cap_en;
    logic [1:0] bit_d;
    logic [NCH-1:0][SAMP_W-1:0] stage;
    sync_st_t   state_q, state_d;

    tdm_pin_sampler u_pins (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_bclk_fall(cfg_bclk_fall),
        .cfg_frm_rise (cfg_frm_rise),
        .bclk_in      (bclk_in),
        .frm_in       (frm_in),
        .sdin0        (sdin0),
        .sdin1        (sdin1),
        .bit_stb      (bit_stb),
        .bit_d        (bit_d),
        .frm_edge     (frm_edge)
    );

    tdm_delay_line #(.DLY_BITS(DLY_BITS)) u_fwd (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_en(bit_stb),
        .cfg_dual(cfg_dual),
        .din     (bit_d),
        .dout0   (sdout0),
        .dout1   (sdout1)
    );

    // I2S: slot 0 starts one bit after the frame edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            edge_q <= 1'b0;
        else if (bit_stb)
            edge_q <= frm_edge;
    end

    assign start_now = bit_stb && (cfg_left ? frm_edge : edge_q);
    assign cap_en    = (state_q != ST_HUNT);

    tdm_slot_capture #(.SLOT_W(SLOT_W), .SAMP_W(SAMP_W), .NCH(NCH)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_stb  (bit_stb),
        .bit_d    (bit_d),
        .start_now(start_now),
        .cap_en   (cap_en),
        .cfg_dual (cfg_dual),
        .stage    (stage)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_HUNT;
        else
            state_q <= state_d;
    end

    // transitions: LOCK, FIRST_DONE, REPUBLISH
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HUNT: if (start_now) state_d = ST_FILL;
            ST_FILL: if (start_now) state_d = ST_RUN;
            ST_RUN:  state_d = ST_RUN;
            default: state_d = ST_HUNT;
        endcase
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ch_word   <= '0;
            frame_vld <= 1'b0;
        end else begin
            frame_vld <= 1'b0;
            unique case (state_q)
                ST_HUNT: ;
                ST_FILL, ST_RUN: begin
                    if (start_now) begin
                        ch_word   <= stage;
                        frame_vld <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/tdm_chain_dac_port_chk.sv
module tdm_chain_dac_port_chk #(
    parameter int SAMP_W = 24,
    parameter int NCH    = 8
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         cfg_dual,
    input logic                         bit_stb,
    input tdm_chain_pkg::sync_st_t      state_q,
    input logic                         frame_vld,
    input logic [NCH-1:0][SAMP_W-1:0]   ch_word,
    input logic                         sdout0,
    input logic                         sdout1
);

    import tdm_chain_pkg::*;

    // R9
    vld_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_vld |=> !frame_vld);

    // R9
    words_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_vld |-> $stable(ch_word));

    // R8
    line1_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_dual |-> !sdout1);

    // R7
    fwd_after_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bit_stb) |-> ($stable(sdout0) && $stable(sdout1)));

    // R10
    vld_needs_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_vld |-> (state_q == ST_RUN));

    // R10
    no_relock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_HUNT) |=> (state_q != ST_HUNT));

    // R1
    zero_before_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_RUN) |-> (ch_word == '0));

endmodule

bind tdm_chain_dac_port tdm_chain_dac_port_chk #(.SAMP_W(SAMP_W), .NCH(NCH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_dual (cfg_dual),
    .bit_stb  (bit_stb),
    .state_q  (state_q),
    .frame_vld(frame_vld),
    .ch_word  (ch_word),
    .sdout0   (sdout0),
    .sdout1   (sdout1)
);

// File: tb/tdm_chain_dac_port_tb.sv
module tdm_chain_dac_port_tb;

    localparam int CLK_PERIOD = 10;
    localparam int HB         = 4;     // system clocks per bit-clock phase
    localparam int NF         = 2;     // data frames per run
    localparam int LEAD       = 6;
    localparam int TAIL       = 40;
    localparam int MAXB       = 1100;
    localparam int NCH        = 8;
    localparam int SAMP_W     = 24;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic rst_n, cfg_dual, cfg_bclk_fall, cfg_frm_rise, cfg_left;
    logic bclk_in, frm_in, sdin0, sdin1;
    logic sdout0, sdout1, frame_vld;
    logic [NCH-1:0][SAMP_W-1:0] ch_word;

    int n_chk = 0;
    int n_bad = 0;
    int vld_cnt = 0;
    int cur_run = 0;
    bit mon_en = 0;
    bit prev_vld = 0;
    bit finished = 0;
    logic h0 [MAXB];
    logic h1 [MAXB];

    tdm_chain_dac_port u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_dual(cfg_dual), .cfg_bclk_fall(cfg_bclk_fall),
        .cfg_frm_rise(cfg_frm_rise), .cfg_left(cfg_left), .bclk_in(bclk_in), .frm_in(frm_in),
        .sdin0(sdin0), .sdin1(sdin1), .sdout0(sdout0), .sdout1(sdout1),
        .ch_word(ch_word), .frame_vld(frame_vld)
    );

    function automatic logic [31:0] word_of(int run, int f, int line, int slot);
        logic [31:0] k;
        k = 32'(f*131 + line*977 + slot*53 + run*7 + 1);
        return k * 32'h9E3779B1;
    endfunction

    function automatic logic [SAMP_W-1:0] exp_ch(int run, int f, int c, bit dual);
        logic [31:0] w;
        if (!dual)           w = word_of(run, f, 0, NCH + c);
        else if (c < NCH/2)  w = word_of(run, f, 0, NCH/2 + c);
        else                 w = word_of(run, f, 1, c);
        return w[31 -: SAMP_W];
    endfunction

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // channel words at each publish pulse
    always @(negedge clk) begin
        if (mon_en) begin
            if (frame_vld) begin
                chk(!prev_vld, $sformatf("R9 pulse width run %0d", cur_run), 32'(prev_vld), 0);
                for (int c = 0; c < NCH; c++) begin
                    logic [SAMP_W-1:0] e;
                    e = exp_ch(cur_run, vld_cnt, c, cfg_dual);
                    chk(ch_word[c] == e,
                        $sformatf("R4 R5 R6 run %0d frame %0d ch%0d", cur_run, vld_cnt, c),
                        32'(ch_word[c]), 32'(e));
                end
                vld_cnt++;
            end
            prev_vld = frame_vld;
        end
    end

    task automatic run_cfg(int r);
        bit dual, fall, rise, left;
        int fb, dl, bedge, total;
        dual = r[0]; fall = r[1]; rise = r[2]; left = r[3];
        fb = dual ? 256 : 512;
        dl = dual ? 128 : 256;
        bedge = LEAD - (left ? 0 : 1);
        total = LEAD + NF*fb + TAIL;

        @(negedge clk);
        mon_en = 0;
        rst_n = 1'b0;
        cfg_dual = dual; cfg_bclk_fall = fall; cfg_frm_rise = rise; cfg_left = left;
        bclk_in = fall; frm_in = ~rise; sdin0 = 1'b0; sdin1 = 1'b0;
        cur_run = r; vld_cnt = 0; prev_vld = 0;
        repeat (5) @(negedge clk);
        // R1 reset state
        chk(ch_word == '0 && !frame_vld && !sdout0 && !sdout1,
            $sformatf("R1 reset state run %0d", r),
            {28'd0, |ch_word, frame_vld, sdout0, sdout1}, 0);
        rst_n = 1'b1;
        mon_en = 1;

        for (int g = 0; g < total; g++) begin
            logic lvl, d0, d1, e0, e1;
            if (g < bedge)
                lvl = ~rise;
            else
                lvl = (((g - bedge) % fb) < fb/2) ? rise : ~rise;
            d0 = 1'b0; d1 = 1'b0;
            if (g >= LEAD && g < LEAD + NF*fb) begin
                int p, f, sl, b;
                logic [31:0] wa, wb;
                p = (g - LEAD) % fb; f = (g - LEAD) / fb;
                sl = p / 32; b = 31 - (p % 32);
                wa = word_of(r, f, 0, sl); wb = word_of(r, f, 1, sl);
                d0 = wa[b]; d1 = wb[b];
            end
            // inactive bit-clock edge: move data and frame clock
            bclk_in = fall; frm_in = lvl; sdin0 = d0; sdin1 = d1;
            h0[g] = d0; h1[g] = d1;
            repeat (HB) @(negedge clk);
            e0 = (g >= dl) ? h0[g-dl] : 1'b0;
            e1 = (dual && g >= dl) ? h1[g-dl] : 1'b0;
            chk(sdout0 == e0 && sdout1 == e1,
                $sformatf("R7 R8 R2 R3 forward run %0d bit %0d", r, g),
                {30'd0, sdout1, sdout0}, {30'd0, e1, e0});
            if (g == LEAD + fb - 1)
                chk(ch_word == '0 && vld_cnt == 0,
                    $sformatf("R1 zero before first frame run %0d", r),
                    32'(vld_cnt) | 32'(|ch_word), 0);
            bclk_in = ~fall;
            repeat (HB) @(negedge clk);
        end
        repeat (8) @(negedge clk);
        chk(vld_cnt == NF, $sformatf("R9 R10 publish count run %0d", r),
            32'(vld_cnt), 32'(NF));
        mon_en = 0;
    endtask

    initial begin
        rst_n = 1'b0;
        cfg_dual = 0; cfg_bclk_fall = 0; cfg_frm_rise = 0; cfg_left = 0;
        bclk_in = 0; frm_in = 1; sdin0 = 0; sdin1 = 0;
        for (int r = 0; r < 16; r++)
            run_cfg(r);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL R9 watchdog run %0d actual=hung expected=done", cur_run);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule